// File: doc/BRIEF.md
# Network Controller Host Register Bank

This block is the host-visible register bank of a network controller. It holds sixty-four 16-bit slots addressed by word index. Each slot obeys its own write rule: a plain store, a store through a bit mask, a store allowed only while the controller sits in software reset, or no store at all. Internal engines raise interrupt causes through a set vector. Software reads the status slot and acknowledges causes by writing ones to it. A single level interrupt is derived from the status slot and the mask slot.

The command slot drives the rest of the controller. A host write to it merges the new command bits into the slot and applies the paired-bit and reset rules. Every accepted command bit is also presented for exactly one cycle on a strobe vector, so the transmit, receive, timer and address-table engines can start work. When an engine finishes, it clears its command bit through a clear vector. Hosts with a byte-wide path can write either half of a slot; the other half keeps its current value.

Top module: `nic_regbank`

## Requirements
- R1: After hardware reset, the slots read as follows: command (slot 0) 0x0094, status (slot 1) 0, mask (slot 2) 0, config (slot 3) 0, config2 (slot 4) 0, end-of-buffer count (slot 5) 0x02F8, revision (slot 6) 0x0004, every other slot 0.
- R2: `irq` is high in any cycle in which the mask slot AND the status slot is nonzero. It follows a change to either slot in the cycle after the clock edge that changed it.
- R3: Status bits are sticky. A host write to slot 1 clears exactly the bits written as 1. A bit on `isr_set` is set at the next edge and wins over a host clear of the same bit in the same cycle.
- R4: The mask slot stores bits 14:0 of the written value; bit 15 always reads 0.
- R5: Config (slot 3) stores the written value AND 0xBFFF, and config2 (slot 4) stores the written value AND 0xF017. Either write takes effect only while command bit 7 (reset) is set; otherwise the slot is unchanged.
- R6: Command bits are: 0 halt transmit, 1 transmit, 2 receiver disable, 3 receiver enable, 4 stop timer, 5 start timer, 7 reset, 8 read resource, 9 load address table. A command write ORs the written value AND 0x03BF into slot 0.
- R7: If the reset bit is set and a command write lacks bit 7, the only effect is that the reset bit clears. No other bit changes and no strobe fires.
- R8: An accepted receiver-disable clears receiver-enable, and an accepted receiver-enable clears receiver-disable (both written: both end up clear). An accepted stop-timer clears start-timer, and an accepted start-timer clears stop-timer.
- R9: An accepted reset command (bit 7) clears bits 0, 1, 8 and 9 and sets bits 2 and 7, after the R8 rules.
- R10: `cmd_strobe` equals the accepted written command bits (value AND 0x03BF) in the single cycle after the write edge, and is 0 otherwise.
- R11: A bit set on `cmd_clr` clears that command bit at the next edge.
- R12: With `wr_byte` high, `wr_data[7:0]` replaces the high byte when `addr[0]` is 1, or the low byte when `addr[0]` is 0. The other byte keeps the slot's current value. For the status slot the other byte is treated as 0, so only the addressed half is acknowledged.
- R13: The revision slot ignores writes. Slots 5 and 7 to 63 store all 16 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Host write strobe |
| wr_byte | input | 1 | Byte-wide write when high |
| addr | input | 7 | Bits 6:1 slot index, bit 0 byte lane |
| wr_data | input | 16 | Write data (byte writes use 7:0) |
| rd_data | output | 16 | Value of the addressed slot |
| isr_set | input | 16 | Engine requests to set status bits |
| cmd_clr | input | 16 | Engine requests to clear command bits |
| irq | output | 1 | Level interrupt |
| cmd_strobe | output | 16 | One-cycle pulse of accepted command bits |

## Verification
Every cycle, the checker confirms four things. An unmasked cause on `isr_set` raises `irq` at the next edge. Status bits survive any cycle without a host status write. Strobes appear only after a command write and only within 0x03BF. The mask top bit stays 0, and the config slot stays frozen while the reset bit is clear. The ordering rules need the bench's scenarios and its per-cycle reference model. These are the paired-bit and software-reset resolution of a single command write, the reset-exit write that changes nothing else, byte-lane merging and lane-limited acknowledge, and the set-over-clear collision.

// File: rtl/nic_regbank.sv
module nic_regbank #(
  parameter int NREG    = 64,
  parameter int CMD_IX  = 0,
  parameter int STAT_IX = 1,
  parameter int MASK_IX = 2,
  parameter int CFG_IX  = 3,
  parameter int CFG2_IX = 4,
  parameter int EOB_IX  = 5,
  parameter int REV_IX  = 6,
  parameter logic [15:0] REV_VAL = 16'h0004,
  parameter logic [15:0] EOB_RST = 16'h02F8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_byte,
  input  logic [$clog2(NREG):0] addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic [15:0] isr_set,
  input  logic [15:0] cmd_clr,
  output logic        irq,
  output logic [15:0] cmd_strobe
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] A_CMD  = AW'(CMD_IX);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_IX);
  localparam logic [AW-1:0] A_MASK = AW'(MASK_IX);
  localparam logic [AW-1:0] A_CFG  = AW'(CFG_IX);
  localparam logic [AW-1:0] A_CFG2 = AW'(CFG2_IX);
  localparam logic [AW-1:0] A_EOB  = AW'(EOB_IX);
  localparam logic [AW-1:0] A_REV  = AW'(REV_IX);
  localparam logic [15:0] CMD_MASK  = 16'h03BF;
  localparam logic [15:0] CMD_RST   = 16'h0094;
  localparam logic [15:0] MASK_KEEP = 16'h7FFF;
  localparam logic [15:0] CFG_KEEP  = 16'hBFFF;
  localparam logic [15:0] CFG2_KEEP = 16'hF017;

  logic [15:0] regs_q [NREG];
  logic [AW-1:0] waddr;
  logic [15:0] cur, wv, cmd_base, cmd_nx, strb_nx, stat_nx, acc;
  logic [15:0] cmd_q, stat_q, mask_q, cfg_q;
  logic in_rst, wr_cmd, wr_stat;

  assign waddr   = addr[AW:1];
  assign cmd_q   = regs_q[A_CMD];
  assign stat_q  = regs_q[A_STAT];
  assign mask_q  = regs_q[A_MASK];
  assign cfg_q   = regs_q[A_CFG];
  assign in_rst  = cmd_q[7];
  assign wr_cmd  = wr_en && waddr == A_CMD;
  assign wr_stat = wr_en && waddr == A_STAT;
  assign rd_data = (waddr == A_REV) ? REV_VAL : regs_q[waddr];
  assign irq     = |(mask_q & stat_q);

  assign cur = (waddr == A_STAT) ? 16'h0000 : rd_data;
  assign wv  = !wr_byte ? wr_data :
               addr[0]  ? {wr_data[7:0], cur[7:0]} : {cur[15:8], wr_data[7:0]};

  assign stat_nx = (stat_q & ~(wr_stat ? wv : 16'h0000)) | isr_set;

  always_comb begin
    cmd_base = cmd_q & ~cmd_clr;
    cmd_nx   = cmd_base;
    strb_nx  = '0;
    acc      = wv & CMD_MASK;
    if (wr_cmd) begin
      if (cmd_base[7] && !wv[7]) begin
        cmd_nx[7] = 1'b0;
      end else begin
        cmd_nx  = cmd_base | acc;
        strb_nx = acc;
        if (acc[2]) cmd_nx[3] = 1'b0;
        if (acc[3]) cmd_nx[2] = 1'b0;
        if (acc[4]) cmd_nx[5] = 1'b0;
        if (acc[5]) cmd_nx[4] = 1'b0;
        if (acc[7]) cmd_nx = (cmd_nx & ~16'h0303) | 16'h0084;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      regs_q[A_CMD] <= CMD_RST;
      regs_q[A_EOB] <= EOB_RST;
      cmd_strobe    <= '0;
    end else begin
      cmd_strobe     <= strb_nx;
      regs_q[A_CMD]  <= cmd_nx;
      regs_q[A_STAT] <= stat_nx;
      if (wr_en) begin
        if (waddr == A_MASK)
          regs_q[A_MASK] <= wv & MASK_KEEP;
        else if (waddr == A_CFG) begin
          if (in_rst) regs_q[A_CFG] <= wv & CFG_KEEP;
        end else if (waddr == A_CFG2) begin
          if (in_rst) regs_q[A_CFG2] <= wv & CFG2_KEEP;
        end else if (waddr != A_CMD && waddr != A_STAT && waddr != A_REV)
          regs_q[waddr] <= wv;
      end
    end
  end
endmodule

module nic_regbank_chk #(parameter int AW = 6, parameter int STAT_IX = 1, parameter int CMD_IX = 0) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] waddr,
  input logic [15:0]   isr_set,
  input logic          irq,
  input logic [15:0]   cmd_strobe,
  input logic [15:0]   stat_q,
  input logic [15:0]   mask_q,
  input logic [15:0]   cmd_q,
  input logic [15:0]   cfg_q
);
  // R2
  irq_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_set & mask_q) != 16'h0 |=> irq);
  // R3
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && waddr == AW'(STAT_IX)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R4
  mask_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !mask_q[15]);
  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[7] |=> $stable(cfg_q));
  // R10
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe != 16'h0 |-> $past(wr_en && waddr == AW'(CMD_IX)));
  // R10
  strobe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe & ~16'h03BF) == 16'h0);
endmodule

bind nic_regbank nic_regbank_chk #(.AW(AW), .STAT_IX(STAT_IX), .CMD_IX(CMD_IX)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .isr_set(isr_set),
  .irq(irq), .cmd_strobe(cmd_strobe), .stat_q(stat_q), .mask_q(mask_q),
  .cmd_q(cmd_q), .cfg_q(cfg_q));

// File: tb/tb_nic_regbank.sv
module tb_nic_regbank;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_byte = 0;
  logic [6:0] addr = '0;
  logic [15:0] wr_data = '0, isr_set = '0, cmd_clr = '0;
  logic [15:0] rd_data, cmd_strobe;
  logic irq;
  int nchk = 0, nerr = 0;
  int m [64];
  int exp_strb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_regbank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .isr_set(isr_set), .cmd_clr(cmd_clr),
    .irq(irq), .cmd_strobe(cmd_strobe));

  task automatic chk(string tag, string what, int act, int expv);
    nchk++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic string tag_of(int w);
    case (w)
      0: return "R6";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      6: return "R13";
      default: return "R12";
    endcase
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m[i]) m[i] = 0;
      m[0] = 'h94; m[5] = 'h2F8; exp_strb = 0;
    end else begin
      int w, cur, v, base, c, s, acc, st, inr;
      w = addr[6:1];
      cur = (w == 1) ? 0 : (w == 6 ? 4 : m[w]);
      if (!wr_byte) v = wr_data;
      else if (addr[0]) v = (wr_data[7:0] << 8) | (cur & 'hFF);
      else v = (cur & 'hFF00) | wr_data[7:0];
      inr = m[0] & 'h80;
      base = m[0] & ~int'(cmd_clr) & 'hFFFF;
      c = base; st = 0;
      if (wr_en && w == 0) begin
        if ((base & 'h80) && !(v & 'h80)) c = base & ~'h80;
        else begin
          acc = v & 'h3BF; c = base | acc; st = acc;
          if (acc & 'h4) c &= ~'h8;
          if (acc & 'h8) c &= ~'h4;
          if (acc & 'h10) c &= ~'h20;
          if (acc & 'h20) c &= ~'h10;
          if (acc & 'h80) c = (c & ~'h303) | 'h84;
        end
      end
      s = m[1];
      if (wr_en && w == 1) s &= ~v;
      s = (s | int'(isr_set)) & 'hFFFF;
      if (wr_en) begin
        if (w == 2) m[2] = v & 'h7FFF;
        else if (w == 3) begin if (inr != 0) m[3] = v & 'hBFFF; end
        else if (w == 4) begin if (inr != 0) m[4] = v & 'hF017; end
        else if (w > 6 || w == 5) m[w] = v;
      end
      m[0] = c; m[1] = s; exp_strb = st;
    end
  end

  // compare against the model every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      int w;
      w = addr[6:1];
      chk("R2", "irq", int'(irq), int'((m[1] & m[2]) != 0));
      chk("R10", "cmd_strobe", int'(cmd_strobe), exp_strb);
      chk(tag_of(w), "rd_data", int'(rd_data), (w == 6) ? 4 : m[w]);
    end
  end

  task automatic wr(int w, int d, bit bytew = 0, bit hi = 0);
    @(posedge clk); #1;
    wr_en = 1; wr_byte = bytew; addr = {w[5:0], hi}; wr_data = d[15:0];
    @(posedge clk); #1;
    wr_en = 0; wr_byte = 0;
  endtask

  task automatic pulse_set(int v, int clrw = -1);
    @(posedge clk); #1;
    isr_set = v[15:0];
    if (clrw >= 0) begin wr_en = 1; addr = {6'd1, 1'b0}; wr_data = clrw[15:0]; end
    @(posedge clk); #1;
    isr_set = '0; wr_en = 0;
  endtask

  task automatic pulse_clr(int v);
    @(posedge clk); #1; cmd_clr = v[15:0];
    @(posedge clk); #1; cmd_clr = '0;
  endtask

  task automatic rd(int w, int expv, string tag);
    addr = {w[5:0], 1'b0};
    @(negedge clk);
    chk(tag, $sformatf("slot %0d", w), int'(rd_data), expv);
  endtask

  task automatic strb(int expv, string tag);
    @(negedge clk); chk(tag, "strobe pulse", int'(cmd_strobe), expv);
    @(negedge clk); chk(tag, "strobe gone", int'(cmd_strobe), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // R1 reset values
    rd(0, 'h0094, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1"); rd(4, 0, "R1");
    rd(5, 'h02F8, "R1"); rd(6, 'h0004, "R1"); rd(40, 0, "R1");
    chk("R1", "irq", int'(irq), 0);
    // R5 config writable in reset
    wr(3, 'hFFFF); rd(3, 'hBFFF, "R5");
    wr(4, 'hFFFF); rd(4, 'hF017, "R5");
    // R7 reset exit changes nothing else
    wr(0, 'h0000); strb(0, "R7"); rd(0, 'h0014, "R7");
    wr(3, 'h1234); rd(3, 'hBFFF, "R5");
    // R8 paired bits, R10 strobe
    wr(0, 'h0008); strb('h0008, "R10"); rd(0, 'h0018, "R8");
    wr(0, 'h0020); strb('h0020, "R10"); rd(0, 'h0028, "R8");
    // R6 / R9 all bits at once with reset
    wr(0, 'hFFFF); strb('h03BF, "R6"); rd(0, 'h0084, "R9");
    wr(0, 'h0000); rd(0, 'h0004, "R7");
    // R11 engine clear
    wr(0, 'h0302); strb('h0302, "R6"); rd(0, 'h0306, "R6");
    pulse_clr('h0002); rd(0, 'h0304, "R11");
    // R4 mask
    wr(2, 'hFFFF); rd(2, 'h7FFF, "R4");
    // R2 / R3 interrupts
    pulse_set('h0400); rd(1, 'h0400, "R3"); chk("R2", "irq set", int'(irq), 1);
    pulse_set('h0400, 'h0400); rd(1, 'h0400, "R3");
    wr(1, 'h0400); rd(1, 0, "R3"); chk("R2", "irq clear", int'(irq), 0);
    wr(2, 'h0001); pulse_set('h0300); chk("R2", "masked", int'(irq), 0);
    pulse_set('h0001); chk("R2", "unmasked", int'(irq), 1);
    // R12 byte lanes on status
    wr(1, 'h01, 1, 0); rd(1, 'h0300, "R12");
    wr(1, 'h01, 1, 1); rd(1, 'h0200, "R12");
    // R12 / R13 generic slot
    wr(10, 'h1234); rd(10, 'h1234, "R13");
    wr(10, 'hAB, 1, 1); rd(10, 'hAB34, "R12");
    wr(10, 'hCD, 1, 0); rd(10, 'hABCD, "R12");
    wr(5, 'h5A5A); rd(5, 'h5A5A, "R13");
    wr(6, 'hFFFF); rd(6, 'h0004, "R13");
    // R9 software reset from running state
    wr(0, 'h0080); strb('h0080, "R10"); rd(0, 'h0084, "R9");
    wr(3, 'h4001); rd(3, 'h0001, "R5");
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule